// File: doc/BRIEF.md
# AXI3 Write Data Interleaving Checker

This block is a passive observer on the write address and write data channels of an AXI3 slave port. It never drives a handshake. Each accepted address is recorded with its ID and burst length in a table of pending transactions, kept in acceptance order. Each accepted data beat is credited to the oldest pending transaction whose ID equals the beat's WID. The beat is then checked against three rules: the first beats of transactions must follow address order, the interleaving depth must be respected, and each burst must have the right length. The slave's interleaving depth is a parameter. A depth of one means no interleaving at all.

Every rule violation raises an error. The checker registers each error as a sticky flag. It also reports the error as a pulse lasting one cycle, together with a numeric code. The flags and pulse are meant for a simulation bench or an on-chip debug monitor. A counter reports how many write bursts have completed.

Top module: `wr_interleave_checker`

## Requirements
- R1: An address or a data beat is taken only on a rising clock edge where its VALID and READY are both high. An offer without READY changes no flag, no pulse and no count, and it does not record the address.
- R2: After a synchronous active-low reset, all sticky flags, the pulse, the code and the burst count are zero, and the pending table is empty.
- R3: Suppose a beat is the first one credited to a transaction while an older pending transaction has had no beat yet. That is a first-beat order error, code 3, sticky bit 2.
- R4: Suppose a first beat arrives while DEPTH or more other transactions already have data in progress. That is a depth error, code 4, sticky bit 3. With DEPTH=1, the sequence A1 B1 is flagged.
- R5: Two two-beat bursts with IDs 0 and 1 raise no error in the order A1 A2 B1 B2 at any depth. The order A1 B1 A2 B2 raises no error at DEPTH=2.
- R6: A beat is always credited to the oldest pending transaction with its ID. Data of a later transaction with the same ID therefore cannot be interleaved into an earlier one: such data shows up as a length error on the earlier burst.
- R7: A beat with WLAST whose beat count differs from AWLEN+1 is a length error, code 5, sticky bit 4. So is a beat without WLAST that reaches AWLEN+1. A beat with WLAST always retires its transaction.
- R8: A beat whose WID matches no pending transaction is a no-address error, code 2, sticky bit 1. This includes a beat accepted in the same cycle as its own address. The beat is dropped and changes no pending entry.
- R9: The table holds 8 pending addresses. An address accepted while 8 are pending is dropped and flagged as overflow, code 1, sticky bit 0.
- R10: Flags stay set until reset. In the cycle after an offending edge, errPulse is high for one cycle and errCode holds the lowest code among that edge's errors. Otherwise errCode is 0.
- R11: burstCount rises by one for every WLAST beat credited to a pending transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| awValid | input | 1 | Address valid |
| awReady | input | 1 | Address ready |
| awId | input | ID_W | Address ID |
| awLen | input | LEN_W | Burst length minus one |
| wValid | input | 1 | Data valid |
| wReady | input | 1 | Data ready |
| wId | input | ID_W | Data beat ID |
| wLast | input | 1 | Last beat of burst |
| errSticky | output | 5 | Sticky flags, bit k set for code k+1 |
| errPulse | output | 1 | One-cycle error pulse |
| errCode | output | 3 | Code of the lowest-numbered error in the pulse cycle |
| burstCount | output | CNT_W | Completed bursts |

## Verification
Assertions check on every cycle that sticky flags never clear, that the pulse and a nonzero code always go together, and that an overflow or a beat into an empty table is flagged on the next cycle. They also check that the burst count never jumps by more than one. Only the bench's scenarios can show how beats are credited among pending transactions: ordering against address order, the depth limit at depths one and two, same-ID interleaving seen as a length fault, and the priority between errors raised on the same edge. For these scenarios, two instances at different depths are compared against a model of the requirements.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int NUM_ERR = 5;

  typedef enum logic [2:0] {
    CODE_NONE     = 3'd0,
    CODE_OVERFLOW = 3'd1,
    CODE_NOADDR   = 3'd2,
    CODE_ORDER    = 3'd3,
    CODE_DEPTH    = 3'd4,
    CODE_LENGTH   = 3'd5
  } errCode_e;

  typedef struct packed {
    logic push;
    logic beat;
    logic close;
  } wicStrobe_t;
endpackage

// File: rtl/wic_pending.sv
module wic_pending
  import wic_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4,
  parameter int PEND  = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(PEND),
  localparam int OCC_W = $clog2(PEND + 1),
  localparam int BC_W  = LEN_W + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wicStrobe_t                   str,
  input  logic [IDX_W-1:0]             idx,
  input  logic [ID_W-1:0]              awId,
  input  logic [LEN_W-1:0]             awLen,
  output logic [OCC_W-1:0]             occ,
  output logic [PEND-1:0][ID_W-1:0]    idArr,
  output logic [PEND-1:0][LEN_W-1:0]   lenArr,
  output logic [PEND-1:0]              startArr,
  output logic [PEND-1:0][BC_W-1:0]    cntArr,
  output logic [CNT_W-1:0]             burstCount
);
  logic [PEND-1:0][ID_W-1:0]  nId;
  logic [PEND-1:0][LEN_W-1:0] nLen;
  logic [PEND-1:0]            nSt;
  logic [PEND-1:0][BC_W-1:0]  nCnt;
  logic [OCC_W-1:0]           nOcc;
  logic [IDX_W-1:0]           pushPos;

  always_comb begin
    nId  = idArr;
    nLen = lenArr;
    nSt  = startArr;
    nCnt = cntArr;
    nOcc = occ;
    if (str.beat) begin
      nSt[idx]  = 1'b1;
      nCnt[idx] = cntArr[idx] + 1'b1;
    end
    if (str.close) begin
      for (int i = 0; i < PEND - 1; i++) begin
        if (i >= int'(idx)) begin
          nId[i]  = idArr[i+1];
          nLen[i] = lenArr[i+1];
          nSt[i]  = startArr[i+1];
          nCnt[i] = cntArr[i+1];
        end
      end
      nId[PEND-1]  = '0;
      nLen[PEND-1] = '0;
      nSt[PEND-1]  = 1'b0;
      nCnt[PEND-1] = '0;
      nOcc = occ - 1'b1;
    end
    pushPos = IDX_W'(nOcc);
    if (str.push) begin
      nId[pushPos]  = awId;
      nLen[pushPos] = awLen;
      nSt[pushPos]  = 1'b0;
      nCnt[pushPos] = '0;
      nOcc = nOcc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ        <= '0;
      idArr      <= '0;
      lenArr     <= '0;
      startArr   <= '0;
      cntArr     <= '0;
      burstCount <= '0;
    end else begin
      occ      <= nOcc;
      idArr    <= nId;
      lenArr   <= nLen;
      startArr <= nSt;
      cntArr   <= nCnt;
      if (str.close) burstCount <= burstCount + 1'b1;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN) int'(occ) <= PEND); // R9
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (burstCount == $past(burstCount)) || (burstCount == $past(burstCount) + 1'b1)); // R11
endmodule

// File: rtl/wic_control.sv
module wic_control
  import wic_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4,
  parameter int PEND  = 8,
  parameter int DEPTH = 2,
  localparam int IDX_W = $clog2(PEND),
  localparam int OCC_W = $clog2(PEND + 1),
  localparam int BC_W  = LEN_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        awValid,
  input  logic                        awReady,
  input  logic                        wValid,
  input  logic                        wReady,
  input  logic [ID_W-1:0]             wId,
  input  logic                        wLast,
  input  logic [OCC_W-1:0]            occ,
  input  logic [PEND-1:0][ID_W-1:0]   idArr,
  input  logic [PEND-1:0][LEN_W-1:0]  lenArr,
  input  logic [PEND-1:0]             startArr,
  input  logic [PEND-1:0][BC_W-1:0]   cntArr,
  output wicStrobe_t                  str,
  output logic [IDX_W-1:0]            idx,
  output logic [NUM_ERR-1:0]          errSticky,
  output logic                        errPulse,
  output logic [2:0]                  errCode
);
  logic awFire, wFire, hit, olderIdle, firstBeat;
  logic [IDX_W-1:0]   hitIdx;
  logic [OCC_W-1:0]   activeOthers;
  logic [BC_W-1:0]    nextCnt, dueCnt;
  logic [NUM_ERR-1:0] ev;
  errCode_e           nextCode, codeQ;

  assign awFire = awValid && awReady;
  assign wFire  = wValid && wReady;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = PEND - 1; i >= 0; i--) begin
      if (i < int'(occ) && idArr[i] == wId) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
    olderIdle    = 1'b0;
    activeOthers = '0;
    for (int i = 0; i < PEND; i++) begin
      if (i < int'(occ)) begin
        if (i < int'(hitIdx) && !startArr[i]) olderIdle = 1'b1;
        if (startArr[i] && i != int'(hitIdx)) activeOthers = activeOthers + 1'b1;
      end
    end
    firstBeat = hit && !startArr[hitIdx];
    nextCnt   = cntArr[hitIdx] + 1'b1;
    dueCnt    = {1'b0, lenArr[hitIdx]} + 1'b1;

    ev = '0;
    ev[0] = awFire && (int'(occ) == PEND);
    ev[1] = wFire && !hit;
    ev[2] = wFire && firstBeat && olderIdle;
    ev[3] = wFire && firstBeat && (int'(activeOthers) >= DEPTH);
    ev[4] = wFire && hit && (wLast ? (nextCnt != dueCnt) : (nextCnt == dueCnt));

    nextCode = CODE_NONE;
    for (int k = NUM_ERR - 1; k >= 0; k--) begin
      if (ev[k]) nextCode = errCode_e'(3'(k + 1));
    end

    str.push  = awFire && (int'(occ) < PEND);
    str.beat  = wFire && hit;
    str.close = wFire && hit && wLast;
    idx       = hitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSticky <= '0;
      errPulse  <= 1'b0;
      codeQ     <= CODE_NONE;
    end else begin
      errSticky <= errSticky | ev;
      errPulse  <= |ev;
      codeQ     <= nextCode;
    end
  end

  assign errCode = codeQ;

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errSticky & $past(errSticky)) == $past(errSticky))); // R10
  AST_PULSE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse == (codeQ != CODE_NONE)); // R10
  AST_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && wReady && occ == '0) |=> (errPulse && errSticky[1])); // R8
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady && int'(occ) == PEND) |=> (errPulse && codeQ == CODE_OVERFLOW)); // R9
endmodule

// File: rtl/wr_interleave_checker.sv
module wr_interleave_checker
  import wic_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4,
  parameter int PEND  = 8,
  parameter int DEPTH = 2,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               awValid,
  input  logic               awReady,
  input  logic [ID_W-1:0]    awId,
  input  logic [LEN_W-1:0]   awLen,
  input  logic               wValid,
  input  logic               wReady,
  input  logic [ID_W-1:0]    wId,
  input  logic               wLast,
  output logic [4:0]         errSticky,
  output logic               errPulse,
  output logic [2:0]         errCode,
  output logic [CNT_W-1:0]   burstCount
);
  localparam int IDX_W = $clog2(PEND);
  localparam int OCC_W = $clog2(PEND + 1);
  localparam int BC_W  = LEN_W + 1;

  wicStrobe_t                str;
  logic [IDX_W-1:0]          idx;
  logic [OCC_W-1:0]          occ;
  logic [PEND-1:0][ID_W-1:0]  idArr;
  logic [PEND-1:0][LEN_W-1:0] lenArr;
  logic [PEND-1:0]            startArr;
  logic [PEND-1:0][BC_W-1:0]  cntArr;

  wic_control #(.ID_W(ID_W), .LEN_W(LEN_W), .PEND(PEND), .DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady),
    .wValid(wValid), .wReady(wReady), .wId(wId), .wLast(wLast),
    .occ(occ), .idArr(idArr), .lenArr(lenArr), .startArr(startArr), .cntArr(cntArr),
    .str(str), .idx(idx), .errSticky(errSticky), .errPulse(errPulse), .errCode(errCode)
  );

  wic_pending #(.ID_W(ID_W), .LEN_W(LEN_W), .PEND(PEND), .CNT_W(CNT_W)) uPend (
    .clk(clk), .rstN(rstN), .str(str), .idx(idx), .awId(awId), .awLen(awLen),
    .occ(occ), .idArr(idArr), .lenArr(lenArr), .startArr(startArr), .cntArr(cntArr),
    .burstCount(burstCount)
  );
endmodule

// File: tb/tb_wr_interleave_checker.sv
module tb_wr_interleave_checker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic awValid = 0, awReady = 0, wValid = 0, wReady = 0, wLast = 0;
  logic [3:0] awId = 0, awLen = 0, wId = 0;
  logic [4:0] stk0, stk1;
  logic pul0, pul1;
  logic [2:0] code0, code1;
  logic [15:0] bc0, bc1;

  always #2.5 clk = ~clk;

  wr_interleave_checker #(.DEPTH(2)) dut (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady), .awId(awId), .awLen(awLen),
    .wValid(wValid), .wReady(wReady), .wId(wId), .wLast(wLast),
    .errSticky(stk0), .errPulse(pul0), .errCode(code0), .burstCount(bc0));

  wr_interleave_checker #(.DEPTH(1)) dutSerial (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady), .awId(awId), .awLen(awLen),
    .wValid(wValid), .wReady(wReady), .wId(wId), .wLast(wLast),
    .errSticky(stk1), .errPulse(pul1), .errCode(code1), .burstCount(bc1));

  int nChecks = 0, nFail = 0;
  bit done = 0;

  int mId[2][8], mLen[2][8], mSt[2][8], mCnt[2][8];
  int mOcc[2], mSticky[2], mPulse[2], mCode[2], mBursts[2];

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelClear(input int m);
    mOcc[m] = 0; mSticky[m] = 0; mPulse[m] = 0; mCode[m] = 0; mBursts[m] = 0;
    for (int i = 0; i < 8; i++) begin mId[m][i] = 0; mLen[m][i] = 0; mSt[m][i] = 0; mCnt[m][i] = 0; end
  endtask

  task automatic modelStep(input int m, input int depth, input bit aw, input int aid, input int alen,
                           input bit w, input int wid, input bit wl);
    int ev = 0, hit = -1, occ0 = mOcc[m], act = 0;
    for (int i = 0; i < mOcc[m]; i++) if (hit < 0 && mId[m][i] == wid) hit = i;
    if (aw && occ0 == 8) ev |= 1;
    if (w) begin
      if (hit < 0) ev |= 2;
      else begin
        if (mSt[m][hit] == 0) begin
          for (int i = 0; i < hit; i++) if (mSt[m][i] == 0) ev |= 4;
          for (int i = 0; i < mOcc[m]; i++) if (i != hit && mSt[m][i] != 0) act++;
          if (act >= depth) ev |= 8;
        end
        mSt[m][hit] = 1;
        mCnt[m][hit] = (mCnt[m][hit] + 1) & 31;
        if (wl ? (mCnt[m][hit] != mLen[m][hit] + 1) : (mCnt[m][hit] == mLen[m][hit] + 1)) ev |= 16;
        if (wl) begin
          for (int i = hit; i < 7; i++) begin
            mId[m][i] = mId[m][i+1]; mLen[m][i] = mLen[m][i+1];
            mSt[m][i] = mSt[m][i+1]; mCnt[m][i] = mCnt[m][i+1];
          end
          mOcc[m]--;
          mBursts[m]++;
        end
      end
    end
    if (aw && occ0 < 8) begin
      mId[m][mOcc[m]] = aid; mLen[m][mOcc[m]] = alen; mSt[m][mOcc[m]] = 0; mCnt[m][mOcc[m]] = 0;
      mOcc[m]++;
    end
    mSticky[m] |= ev;
    mPulse[m] = (ev != 0);
    mCode[m] = 0;
    for (int k = 4; k >= 0; k--) if (ev[k]) mCode[m] = k + 1;
  endtask

  task automatic tick(input bit awv, input bit awr, input int aid, input int alen,
                      input bit wv, input bit wr, input int wid, input bit wl);
    @(negedge clk);
    awValid = awv; awReady = awr; awId = 4'(aid); awLen = 4'(alen);
    wValid = wv; wReady = wr; wId = 4'(wid); wLast = wl;
    for (int m = 0; m < 2; m++) begin
      if (!rstN) modelClear(m);
      else modelStep(m, (m == 0) ? 2 : 1, awv && awr, aid, alen, wv && wr, wid, wl);
    end
    @(posedge clk);
    #1;
    chk("R10 sticky d2", int'(stk0), mSticky[0]);
    chk("R10 pulse d2", int'(pul0), mPulse[0]);
    chk("R10 code d2", int'(code0), mCode[0]);
    chk("R11 bursts d2", int'(bc0), mBursts[0]);
    chk("R10 sticky d1", int'(stk1), mSticky[1]);
    chk("R10 pulse d1", int'(pul1), mPulse[1]);
    chk("R10 code d1", int'(code1), mCode[1]);
    chk("R11 bursts d1", int'(bc1), mBursts[1]);
  endtask

  task automatic idle(); tick(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic addr(input int aid, input int alen); tick(1, 1, aid, alen, 0, 0, 0, 0); endtask
  task automatic beat(input int wid, input bit wl); tick(0, 0, 0, 0, 1, 1, wid, wl); endtask

  task automatic doReset();
    rstN = 1'b0;
    idle();
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    doReset();
    // R2: reset state
    chk("R2 sticky", int'(stk0 | stk1), 0);
    chk("R2 pulse", int'(pul0 | pul1), 0);
    chk("R2 count", int'(bc0 | bc1), 0);

    // R5 / R11: A1 A2 B1 B2
    addr(0, 1); addr(1, 1);
    beat(0, 0); beat(0, 1); beat(1, 0); beat(1, 1);
    chk("R5 in-order d2", int'(stk0), 0);
    chk("R5 in-order d1", int'(stk1), 0);
    chk("R11 two bursts", int'(bc0), 2);

    // R4 / R5: A1 B1 A2 B2
    doReset();
    addr(0, 1); addr(1, 1);
    beat(0, 0); beat(1, 0); beat(0, 1); beat(1, 1);
    chk("R5 interleave legal at d2", int'(stk0), 0);
    chk("R4 interleave flagged at d1", int'(stk1), 5'b01000);

    // R3 / R10: first-beat order
    doReset();
    addr(0, 0); addr(1, 0);
    beat(1, 1);
    chk("R3 order code", int'(code0), 3);
    chk("R10 pulse high", int'(pul0), 1);
    beat(0, 1);
    chk("R10 pulse one cycle", int'(pul0), 0);
    chk("R3 sticky kept", int'(stk0), 5'b00100);

    // R8: data without address, beat dropped
    doReset();
    beat(2, 1);
    chk("R8 code", int'(code0), 2);
    addr(2, 0); beat(2, 1);
    chk("R8 later burst clean", int'(pul0), 0);
    chk("R8 burst counted", int'(bc0), 1);

    // R1: offers without ready
    doReset();
    tick(1, 0, 3, 0, 1, 0, 3, 1);
    tick(1, 0, 3, 0, 1, 0, 3, 1);
    chk("R1 no effect", int'(stk0 | {4'b0, pul0}), 0);
    beat(3, 1);
    chk("R1 address not recorded", int'(code0), 2);

    // R9 / R10: overflow plus no-address on one edge
    doReset();
    for (int i = 0; i < 8; i++) addr(i % 4, 0);
    tick(1, 1, 5, 0, 1, 1, 9, 1);
    chk("R10 priority code", int'(code0), 1);
    chk("R9 sticky", int'(stk0), 5'b00011);
    beat(5, 1);
    chk("R9 dropped address", int'(code0), 2);

    // R6 / R7: same-ID interleave, missing last
    doReset();
    addr(0, 1); addr(0, 0);
    beat(0, 1);
    chk("R6 same-ID seen as length", int'(code0), 5);
    doReset();
    addr(1, 0);
    beat(1, 0);
    chk("R7 missing WLAST", int'(code0), 5);

    // random phases against the model
    for (int p = 0; p < 4; p++) begin
      doReset();
      for (int c = 0; c < 400; c++) begin
        int wid;
        wid = $urandom % 4;
        if (mOcc[0] > 0 && ($urandom % 4) != 0) wid = mId[0][$urandom % mOcc[0]];
        tick(($urandom % 3) == 0, ($urandom % 4) != 0, $urandom % 4, $urandom % 4,
             ($urandom % 2) == 0, ($urandom % 4) != 0, wid, ($urandom % 3) == 0);
      end
    end
    finishRun();
  end
endmodule